// File: doc/BRIEF.md
# Fairness-Aware Chip Transaction Queue

This block is the per-chip transaction queue of a flash back end. Each arriving flash transaction carries a transaction tag, a flow tag, a read/write bit, the intensity class of its flow and an estimate of its slowdown. The block chooses where the transaction goes. The classification of flows and the slowdown arithmetic happen elsewhere; both arrive as inputs.

The queue is split into two contiguous regions. Transactions from light (low-intensity) flows sit nearest the head. Transactions from heavy (high-intensity) flows sit behind them, toward the tail. A boundary count marks where the light region ends. A new transaction goes into the region of its class, at the slot that keeps that region sorted by falling slowdown estimate. The other region keeps its order.

Transactions leave only from the head, so light traffic is always served ahead of heavy traffic. When the queue is full, an insert is held back by a ready/valid handshake. A pop in the same cycle as an insert takes effect first, so a full queue that is popped can accept a new transaction in that cycle.

Top module: `fair_chip_queue`

## Requirements
- R1: After reset the queue is empty: `head_valid` is 0 and `ins_ready` is 1.
- R2: An accepted light transaction (`ins_hi`=0) is placed ahead of every heavy entry. Whenever any light entry is queued, the head holds a light entry.
- R3: An accepted heavy transaction (`ins_hi`=1) is placed behind every light entry. It leaves only after all light entries queued before it, and after any light entries that arrive before it reaches the head.
- R4: Within each region, entries leave in order of non-increasing slowdown estimate (`ins_slow`, unsigned).
- R5: Entries of the same region with equal slowdown estimates leave in their arrival order.
- R6: An insertion into one region leaves the relative order of the other region's entries unchanged.
- R7: `head_pop` with `head_valid` high removes exactly the head entry. `head_pop` on an empty queue changes nothing.
- R8: With `DEPTH` entries queued and no pop, `ins_ready` is 0, an offered insert is refused, and the queued contents stay unchanged.
- R9: When an insert and a pop fall in the same cycle, the pop is applied first. A full queue that is popped accepts the insert in that cycle, and the new entry is sorted among the remaining entries.
- R10: The queue holds exactly `DEPTH` entries (16 by default): `DEPTH` inserts into an empty queue are all accepted, and `ins_ready` drops only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | An insert is offered |
| ins_ready | output | 1 | The queue can take the offered insert this cycle |
| ins_tid | input | TID_W | Transaction tag |
| ins_fid | input | FID_W | Flow tag |
| ins_write | input | 1 | 1 = write, 0 = read |
| ins_hi | input | 1 | Flow class: 1 = heavy, 0 = light |
| ins_slow | input | SLOW_W | Slowdown estimate, unsigned |
| head_valid | output | 1 | The head slot holds an entry |
| head_pop | input | 1 | Remove the head entry |
| head_tid | output | TID_W | Transaction tag at the head |
| head_fid | output | FID_W | Flow tag at the head |
| head_write | output | 1 | Read/write bit at the head |
| head_hi | output | 1 | Class of the head entry |
| head_slow | output | SLOW_W | Slowdown estimate at the head |

## Verification
The bench targets the region boundary. A light insert into a queue that holds only heavy entries must become the new head. A design that sorted across both regions would put it behind a heavy entry that has a larger estimate. Ties on the estimate are aimed at the stable ordering: a comparison that uses `>` where `>=` is needed would reverse entries that arrive with the same estimate. Full-queue cases cover both a refused insert, where a design that wrote anyway would drop or duplicate an entry, and an insert paired with a pop. If the pop were applied after the insert in that case, the new entry would be lost or the boundary count would drift. A popped light entry must also shrink the boundary, otherwise later light inserts land among heavy entries.

// File: rtl/fair_chip_queue.sv
module fair_chip_queue #(
  parameter int DEPTH  = 16,
  parameter int TID_W  = 8,
  parameter int FID_W  = 4,
  parameter int SLOW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [TID_W-1:0]  ins_tid,
  input  logic [FID_W-1:0]  ins_fid,
  input  logic              ins_write,
  input  logic              ins_hi,
  input  logic [SLOW_W-1:0] ins_slow,
  output logic              head_valid,
  input  logic              head_pop,
  output logic [TID_W-1:0]  head_tid,
  output logic [FID_W-1:0]  head_fid,
  output logic              head_write,
  output logic              head_hi,
  output logic [SLOW_W-1:0] head_slow
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int S_LO  = TID_W + FID_W;
  localparam int W_BIT = S_LO + SLOW_W;
  localparam int H_BIT = W_BIT + 1;
  localparam int EW    = H_BIT + 1;

  logic [EW-1:0] mem  [DEPTH];
  logic [EW-1:0] post [DEPTH];
  logic [EW-1:0] nxt  [DEPTH];
  logic [CW-1:0] cnt, lo, pcnt, plo, r_beg, r_end, pos;
  logic          do_pop, do_ins;
  logic [EW-1:0] ins_e;

  assign do_pop    = head_pop && (cnt != '0);
  assign ins_ready = (cnt != CW'(DEPTH)) || do_pop;
  assign do_ins    = ins_valid && ins_ready;
  assign ins_e     = {ins_hi, ins_write, ins_slow, ins_fid, ins_tid};

  assign pcnt  = cnt - CW'(do_pop);
  assign plo   = lo - CW'(do_pop && (lo != '0));
  assign r_beg = ins_hi ? plo : '0;
  assign r_end = ins_hi ? pcnt : plo;

  assign head_valid = (cnt != '0);
  assign head_tid   = mem[0][TID_W-1:0];
  assign head_fid   = mem[0][S_LO-1:TID_W];
  assign head_slow  = mem[0][W_BIT-1:S_LO];
  assign head_write = mem[0][W_BIT];
  assign head_hi    = mem[0][H_BIT];

  always_comb begin
    pos = r_beg;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) >= r_beg && CW'(i) < r_end && post[i][W_BIT-1:S_LO] >= ins_slow)
        pos = pos + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g == DEPTH - 1) begin : g_last
      assign post[g] = do_pop ? '0 : mem[g];
    end else begin : g_mid
      assign post[g] = do_pop ? mem[g+1] : mem[g];
    end
    if (g == 0) begin : g_first
      assign nxt[g] = (do_ins && pos == '0) ? ins_e : post[g];
    end else begin : g_rest
      assign nxt[g] = (!do_ins || CW'(g) < pos) ? post[g] :
                      (CW'(g) == pos) ? ins_e : post[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lo  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= pcnt + CW'(do_ins);
      lo  <= plo + CW'(do_ins && !ins_hi);
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH) && lo <= cnt);

  p_head_light_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo != '0 |-> !head_hi);

  p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !head_pop) |-> !ins_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=> ($stable(cnt) && $stable(mem[0])));

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && head_pop && !ins_valid) |=> !head_valid);

  p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && head_pop && ins_valid) |=> cnt == CW'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    p_class_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(g) < lo |-> !mem[g][H_BIT]);
    p_class_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(g) >= lo && CW'(g) < cnt) |-> mem[g][H_BIT]);
    if (g < DEPTH - 1) begin : g_pair
      p_sorted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((CW'(g + 1) < lo) || (CW'(g) >= lo && CW'(g + 1) < cnt)) |->
          mem[g][W_BIT-1:S_LO] >= mem[g+1][W_BIT-1:S_LO]);
    end
  end
endmodule

// File: tb/test_fair_chip_queue.sv
module test_fair_chip_queue;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic       hi;
    logic       w;
    logic [7:0] slow;
    logic [3:0] fid;
    logic [7:0] tid;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0, ins_write = 0, ins_hi = 0, head_pop = 0;
  logic [7:0] ins_tid = 0, ins_slow = 0;
  logic [3:0] ins_fid = 0;
  logic ins_ready, head_valid, head_write, head_hi;
  logic [7:0] head_tid, head_slow;
  logic [3:0] head_fid;

  int checks = 0, errors = 0, cyc = 0;
  ent_t mq[$];

  always #2 clk = ~clk;

  fair_chip_queue #(.DEPTH(DEPTH)) i_fair_chip_queue (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_tid(ins_tid),
    .ins_fid(ins_fid), .ins_write(ins_write), .ins_hi(ins_hi), .ins_slow(ins_slow),
    .head_valid(head_valid), .head_pop(head_pop), .head_tid(head_tid),
    .head_fid(head_fid), .head_write(head_write), .head_hi(head_hi),
    .head_slow(head_slow));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic void model_insert(ent_t e);
    int pos = 0;
    if (!e.hi) begin
      foreach (mq[i]) if (!mq[i].hi && mq[i].slow >= e.slow) pos = i + 1;
    end else begin
      foreach (mq[i]) if (!mq[i].hi) pos = i + 1;
      foreach (mq[i]) if (mq[i].hi && mq[i].slow >= e.slow) pos = i + 1;
    end
    mq.insert(pos, e);
  endfunction

  task automatic step(input logic v, input logic hi, input logic [7:0] slow,
                      input logic [7:0] tid, input logic pop, input string req);
    logic exp_rdy;
    ent_t act, expv;
    @(negedge clk);
    ins_valid = v; ins_hi = hi; ins_slow = slow; ins_tid = tid;
    ins_fid = tid[3:0]; ins_write = tid[0]; head_pop = pop;
    #1;
    exp_rdy = (mq.size() < DEPTH) || (pop && mq.size() > 0);
    act  = {head_hi, head_write, head_slow, head_fid, head_tid};
    expv = (mq.size() > 0) ? mq[0] : '0;
    checks++;
    if (head_valid !== (mq.size() > 0) || ins_ready !== exp_rdy ||
        (mq.size() > 0 && act !== expv)) begin
      errors++;
      $display("FAIL %s: actual valid=%0b ready=%0b head=%h expected valid=%0b ready=%0b head=%h",
               req, head_valid, ins_ready, act, mq.size() > 0, exp_rdy, expv);
    end
    @(posedge clk);
    if (pop && mq.size() > 0) void'(mq.pop_front());
    if (v && exp_rdy) model_insert({hi, tid[0], slow, tid[3:0], tid});
  endtask

  task automatic drain(input string req);
    while (mq.size() > 0) step(0, 0, 0, 0, 1, req);
    step(0, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");

    // R7: pop on empty queue is ignored
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, "R7");

    // R2 R3 R4: mixed classes and estimates
    step(1, 1, 8'd50, 8'd1, 0, "R3");
    step(1, 1, 8'd90, 8'd2, 0, "R4");
    step(1, 0, 8'd10, 8'd3, 0, "R2");
    step(1, 0, 8'd70, 8'd4, 0, "R4");
    step(1, 1, 8'd20, 8'd5, 0, "R3");
    step(1, 0, 8'd40, 8'd6, 0, "R2");
    drain("R4");

    // R5: ties kept in arrival order in both regions
    for (int k = 0; k < 4; k++) step(1, 0, 8'd33, 8'(16 + k), 0, "R5");
    for (int k = 0; k < 3; k++) step(1, 1, 8'd33, 8'(32 + k), 0, "R5");
    drain("R5");

    // R6: heavy region order untouched by light inserts
    step(1, 1, 8'd60, 8'd40, 0, "R6");
    step(1, 1, 8'd30, 8'd41, 0, "R6");
    step(1, 1, 8'd45, 8'd42, 0, "R6");
    step(1, 0, 8'd5,  8'd43, 0, "R6");
    step(1, 0, 8'd99, 8'd44, 0, "R6");
    drain("R6");

    // R10: exactly DEPTH inserts accepted, R8: then refused
    for (int k = 0; k < DEPTH; k++)
      step(1, k[0], 8'(k * 7 % 23), 8'(64 + k), 0, "R10");
    step(1, 0, 8'd255, 8'd99, 0, "R8");
    step(1, 1, 8'd255, 8'd98, 0, "R8");
    // R9: full + pop accepts, sorted among the remaining entries
    step(1, 0, 8'd200, 8'd97, 1, "R9");
    step(1, 1, 8'd1,   8'd96, 1, "R9");
    drain("R9");

    // R9: pop and insert on a non-full queue; new entry becomes head
    step(1, 1, 8'd10, 8'd110, 0, "R9");
    step(1, 0, 8'd3,  8'd111, 1, "R9");
    step(1, 0, 8'd8,  8'd112, 1, "R9");
    drain("R9");

    // R4: longer pseudo-random mix with interleaved pops
    for (int k = 0; k < 400; k++)
      step($urandom_range(0, 2) != 0, 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 15)), 8'(k), $urandom_range(0, 2) == 0, "R4");
    drain("R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule